// File: doc/BRIEF.md
# Dual-Channel ATA Task-File Register Block

This block holds the byte-wide task-file registers of a two-channel ATA host-side device behind an 8-bit I/O bus. It decodes the command-block and control-block address windows of both channels. For each channel it keeps one shared set of error, features, status, command, drive/head and control registers. It also keeps a separate sector count, sector number and cylinder pair for each of the two drives that can sit on that channel. The bus side is a plain address, write data, write strobe, read strobe and read data. Writes take effect at the next rising clock edge. Read data is combinational while the read strobe is high and is zero otherwise.

A static configuration input gives the kind of every drive: absent, disk or packet. The block runs the two-phase software reset through the reset bit of the control register. Setting the bit puts the channel into a busy state. Clearing it completes the reset and loads each drive's signature values. Selecting an absent drive raises an abort condition, and the task-file reads for that drive collapse to fixed values. Data-port transfers are not modelled. Command bytes are latched and nothing else happens.

Top module: `ata_taskfile_regs`

## Requirements
- R1: Channel 0 responds to addresses whose value ANDed with 0xFFF8 equals 0x01F0, or ANDed with 0xFFFE equals 0x03F6. Channel 1 uses 0x0170 and 0x0376 in the same way. An access to one channel never changes what the other channel reads back.
- R2: After reset, error reads 0x01, drive/head reads 0x00 and status reads 0x00. For every drive, sector count and sector number read 0x01 and both cylinder bytes read 0x00. The control register holds 0x08.
- R3: A control write (offset 6 of the control window) in which bit 2 goes from 0 to 1 sets status to 0x90 and error to 0x01, and clears the command register.
- R4: A control write in which bit 2 goes from 1 to 0 clears status bit 7, sets status bit 6 and clears drive/head bits 3..0. On both drives it sets sector count and sector number to 0x01. It sets the cylinder to 0xEB14 (high byte 0xEB, low byte 0x14) for a packet drive and to 0x0000 for any other kind.
- R5: Every control write stores the written byte, and that stored byte is the reference for the next edge test. A write that leaves bit 2 unchanged does not alter status.
- R6: A drive/head write (offset 6) stores the byte ORed with 0xA0. If the drive named by bit 4 of the written byte is absent, error bit 2 and status bit 0 are set, and all other bits keep their values.
- R7: At offset 1 a read returns the error register. A write goes to the features register and leaves the error read-back unchanged.
- R8: Offsets 2, 3, 4 and 5 (sector count, sector number, cylinder low, cylinder high) are kept per drive. Both reads and writes go to the drive chosen by drive/head bit 4.
- R9: Offset 7 of a control window (0x03F7, 0x0377) always reads 0xFF, whatever drive is selected.
- R10: While the selected drive is absent, a drive/head read returns 0xA0. Reads at offsets 1 to 5 and 7 of the command window, and at offset 6 of the control window, return 0x00.
- R11: Reads at command offset 7 and at control offset 6 both return status. Command writes (command offset 7) and data-port accesses (offset 0) do not change any read-back value.
- R12: Drive kind is 2 bits per drive: bits [4c+2d+1 : 4c+2d] of driveKind give drive d of channel c. 2'b01 is disk, 2'b10 is packet, and 2'b00 or 2'b11 is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset to the power-on values |
| busAddr | input | 16 | I/O address |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe, taken at the rising edge |
| busRd | input | 1 | Read strobe; read data is valid while high |
| busRdData | output | 8 | Read data, zero when busRd is low |
| driveKind | input | 8 | Static kind of each of the four drives |

## Verification
The bench sweeps the per-drive registers of both drives on one channel with distinct computed patterns. A design that shares one register set between drives, or that indexes drives by the wrong bit, returns the other drive's bytes. The bench drives the reset bit through rise, hold, fall and hold. A design that resets on the level of the bit, or compares against a control value it never stored, either re-enters busy or never releases it. After release the bench reads back the signature bytes of both a packet drive and a disk drive. It also selects an absent drive and checks the 0xA0 and 0x00 read-backs, the sticky abort flags once a present drive is selected again, and the constant 0xFF at control offset 7. The other channel is re-read after each step, so a design that decodes across channels shows up there.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int NUM_CH   = 2;
  localparam int NUM_DRV  = 2;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int KIND_W   = 2;

  typedef enum logic [1:0] {
    KIND_ABSENT = 2'b00,
    KIND_DISK   = 2'b01,
    KIND_PACKET = 2'b10,
    KIND_RSVD   = 2'b11
  } drvKind_e;

  typedef enum logic [3:0] {
    RD_NONE, RD_ERR, RD_COUNT, RD_SECNUM, RD_CYLLO, RD_CYLHI,
    RD_DRVHEAD, RD_STATUS, RD_ONES
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] chHit;
    logic   wrFeat;
    logic   wrCount;
    logic   wrSecNum;
    logic   wrCylLo;
    logic   wrCylHi;
    logic   wrDrvHead;
    logic   wrCmd;
    logic   wrCtrl;
    rdSel_e rdSel;
  } tfStrobe_t;

  function automatic logic kindPresent(input logic [KIND_W-1:0] k);
    return (k == KIND_DISK) || (k == KIND_PACKET);
  endfunction
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
#(
  parameter logic [NUM_CH*ADDR_W-1:0] CMD_BASES = {16'h0170, 16'h01F0},
  parameter logic [NUM_CH*ADDR_W-1:0] CTL_BASES = {16'h0376, 16'h03F6}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output tfStrobe_t         strobe
);
  localparam logic [ADDR_W-1:0] CMD_MASK = ~ADDR_W'(7);
  localparam logic [ADDR_W-1:0] CTL_MASK = ~ADDR_W'(1);

  logic [NUM_CH-1:0] cmdHit;
  logic [NUM_CH-1:0] ctlHit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign cmdHit[c] = (busAddr & CMD_MASK) == CMD_BASES[c*ADDR_W +: ADDR_W];
    assign ctlHit[c] = (busAddr & CTL_MASK) == CTL_BASES[c*ADDR_W +: ADDR_W];
  end

  logic anyCmd, anyCtl;
  assign anyCmd = |cmdHit;
  assign anyCtl = |ctlHit;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    strobe.chHit = cmdHit | ctlHit;
    if (anyCmd) begin
      unique case (busAddr[2:0])
        3'd1: begin strobe.wrFeat    = busWr; strobe.rdSel = RD_ERR;     end
        3'd2: begin strobe.wrCount   = busWr; strobe.rdSel = RD_COUNT;   end
        3'd3: begin strobe.wrSecNum  = busWr; strobe.rdSel = RD_SECNUM;  end
        3'd4: begin strobe.wrCylLo   = busWr; strobe.rdSel = RD_CYLLO;   end
        3'd5: begin strobe.wrCylHi   = busWr; strobe.rdSel = RD_CYLHI;   end
        3'd6: begin strobe.wrDrvHead = busWr; strobe.rdSel = RD_DRVHEAD; end
        3'd7: begin strobe.wrCmd     = busWr; strobe.rdSel = RD_STATUS;  end
        default: ;
      endcase
    end else if (anyCtl) begin
      if (!busAddr[0]) begin
        strobe.wrCtrl = busWr;
        strobe.rdSel  = RD_STATUS;
      end else begin
        strobe.rdSel  = RD_ONES;
      end
    end
  end

  // R1: at most one channel claims any address
  p_one_channel_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.chHit));
endmodule

// File: rtl/ata_tf_chan.sv
module ata_tf_chan
  import ata_tf_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      en,
  input  tfStrobe_t                 strobe,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_DRV*KIND_W-1:0] kinds,
  output logic [DATA_W-1:0]         rdData
);
  localparam logic [DATA_W-1:0] ERR_INIT    = 8'h01;
  localparam logic [DATA_W-1:0] CTRL_INIT   = 8'h08;
  localparam logic [DATA_W-1:0] ST_RESET    = 8'h90;
  localparam logic [DATA_W-1:0] DH_FORCED   = 8'hA0;
  localparam logic [15:0]       PACKET_SIG  = 16'hEB14;
  localparam int SEL_BIT = 4;
  localparam int SRST_BIT = 2;
  localparam int ST_BUSY = 7, ST_READY = 6, ST_ERR = 0, ER_ABORT = 2;

  logic [DATA_W-1:0] errReg, featReg, drvHead, statusReg, cmdReg, ctrlReg;
  logic [DATA_W-1:0] cnt [NUM_DRV];
  logic [DATA_W-1:0] secNum [NUM_DRV];
  logic [DATA_W-1:0] cylLo [NUM_DRV];
  logic [DATA_W-1:0] cylHi [NUM_DRV];

  logic sel, newSel, selPresent, newPresent, srstRise, srstFall;
  assign sel        = drvHead[SEL_BIT];
  assign newSel     = wrData[SEL_BIT];
  assign selPresent = kindPresent(kinds[sel*KIND_W +: KIND_W]);
  assign newPresent = kindPresent(kinds[newSel*KIND_W +: KIND_W]);
  assign srstRise   = en && strobe.wrCtrl && !ctrlReg[SRST_BIT] &&  wrData[SRST_BIT];
  assign srstFall   = en && strobe.wrCtrl &&  ctrlReg[SRST_BIT] && !wrData[SRST_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errReg    <= ERR_INIT;
      featReg   <= '0;
      drvHead   <= '0;
      statusReg <= '0;
      cmdReg    <= '0;
      ctrlReg   <= CTRL_INIT;
      for (int d = 0; d < NUM_DRV; d++) begin
        cnt[d]    <= 8'h01;
        secNum[d] <= 8'h01;
        cylLo[d]  <= '0;
        cylHi[d]  <= '0;
      end
    end else if (en) begin
      if (strobe.wrFeat)   featReg     <= wrData;
      if (strobe.wrCount)  cnt[sel]    <= wrData;
      if (strobe.wrSecNum) secNum[sel] <= wrData;
      if (strobe.wrCylLo)  cylLo[sel]  <= wrData;
      if (strobe.wrCylHi)  cylHi[sel]  <= wrData;
      if (strobe.wrCmd)    cmdReg      <= wrData;
      if (strobe.wrDrvHead) begin
        drvHead <= wrData | DH_FORCED;
        if (!newPresent) begin
          errReg[ER_ABORT]  <= 1'b1;
          statusReg[ST_ERR] <= 1'b1;
        end
      end
      if (strobe.wrCtrl) begin
        if (srstRise) begin
          statusReg <= ST_RESET;
          errReg    <= ERR_INIT;
          cmdReg    <= '0;
        end else if (srstFall) begin
          statusReg[ST_BUSY]  <= 1'b0;
          statusReg[ST_READY] <= 1'b1;
          drvHead[3:0]        <= '0;
          for (int d = 0; d < NUM_DRV; d++) begin
            cnt[d]    <= 8'h01;
            secNum[d] <= 8'h01;
            if (kinds[d*KIND_W +: KIND_W] == KIND_PACKET) begin
              cylLo[d] <= PACKET_SIG[7:0];
              cylHi[d] <= PACKET_SIG[15:8];
            end else begin
              cylLo[d] <= '0;
              cylHi[d] <= '0;
            end
          end
        end
        ctrlReg <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdSel == RD_ONES) begin
      rdData = 8'hFF;
    end else if (!selPresent) begin
      if (strobe.rdSel == RD_DRVHEAD) rdData = DH_FORCED;
    end else begin
      unique case (strobe.rdSel)
        RD_ERR:     rdData = errReg;
        RD_COUNT:   rdData = cnt[sel];
        RD_SECNUM:  rdData = secNum[sel];
        RD_CYLLO:   rdData = cylLo[sel];
        RD_CYLHI:   rdData = cylHi[sel];
        RD_DRVHEAD: rdData = drvHead;
        RD_STATUS:  rdData = statusReg;
        default:    rdData = '0;
      endcase
    end
  end

  // R3: rising reset bit enters the busy state and clears the command byte
  p_reset_enter_r3: assert property (@(posedge clk) disable iff (!rstN)
    srstRise |=> (statusReg == ST_RESET) && (errReg == ERR_INIT) && (cmdReg == '0));
  // R4: falling reset bit releases busy and raises ready
  p_reset_leave_r4: assert property (@(posedge clk) disable iff (!rstN)
    srstFall |=> !statusReg[ST_BUSY] && statusReg[ST_READY] && (drvHead[3:0] == '0));
  // R5: control write is stored as written
  p_ctrl_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    (en && strobe.wrCtrl) |=> ctrlReg == $past(wrData));
  // R6: reserved drive/head bits always read as set after a write
  p_dh_forced_r6: assert property (@(posedge clk) disable iff (!rstN)
    (en && strobe.wrDrvHead) |=> drvHead[7] && drvHead[5]);
  // R6: selecting an absent drive flags abort
  p_absent_abort_r6: assert property (@(posedge clk) disable iff (!rstN)
    (en && strobe.wrDrvHead && !newPresent) |=> errReg[ER_ABORT] && statusReg[ST_ERR]);
  // R7: offset-1 writes land in the features register
  p_feat_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    (en && strobe.wrFeat) |=> featReg == $past(wrData));
endmodule

// File: rtl/ata_tf_datapath.sv
module ata_tf_datapath
  import ata_tf_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  tfStrobe_t                        strobe,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [NUM_CH*NUM_DRV*KIND_W-1:0] driveKind,
  output logic [DATA_W-1:0]                rdData
);
  localparam int CH_KIND_W = NUM_DRV * KIND_W;

  logic [DATA_W-1:0] chRd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ata_tf_chan u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .en     (strobe.chHit[c]),
      .strobe (strobe),
      .wrData (wrData),
      .kinds  (driveKind[c*CH_KIND_W +: CH_KIND_W]),
      .rdData (chRd[c])
    );
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (strobe.chHit[c]) rdData = rdData | chRd[c];
  end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        busRdData,
  input  logic [7:0]        driveKind
);
  tfStrobe_t         strobe;
  logic [DATA_W-1:0] dpRd;

  ata_tf_decode u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobe  (strobe)
  );

  ata_tf_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .driveKind (driveKind),
    .rdData    (dpRd)
  );

  assign busRdData = busRd ? dpRd : '0;
endmodule

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  // R12: ch0 d0 disk, ch0 d1 absent, ch1 d0 packet, ch1 d1 disk
  logic [7:0]  driveKind = 8'b01_10_00_01;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ata_taskfile_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .driveKind(driveKind)
  );

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] got;
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 got = busRdData;
    busRd = 1'b0;
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr %h got %h exp %h", tag, a, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 power-on values on both channels
    chk("R2", 16'h01F1, 8'h01);
    chk("R2", 16'h01F2, 8'h01);
    chk("R2", 16'h01F3, 8'h01);
    chk("R2", 16'h01F4, 8'h00);
    chk("R2", 16'h01F5, 8'h00);
    chk("R2", 16'h01F6, 8'h00);
    chk("R2", 16'h01F7, 8'h00);
    chk("R2", 16'h0171, 8'h01);
    chk("R2", 16'h0174, 8'h00);
    chk("R2", 16'h0175, 8'h00);
    // R9 constant read
    chk("R9", 16'h03F7, 8'hFF);
    chk("R9", 16'h0377, 8'hFF);

    // R8 sweep of per-drive registers on channel 1
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, b;
      a = 8'(i * 17);
      b = ~a;
      wr(16'h0176, 8'h00);
      wr(16'h0172, a); wr(16'h0173, a + 8'd1); wr(16'h0174, a ^ 8'h5A); wr(16'h0175, a + 8'd3);
      wr(16'h0176, 8'h10);
      wr(16'h0172, b); wr(16'h0173, b + 8'd1); wr(16'h0174, b ^ 8'h5A); wr(16'h0175, b + 8'd3);
      chk("R8", 16'h0172, b); chk("R8", 16'h0173, b + 8'd1);
      chk("R8", 16'h0174, b ^ 8'h5A); chk("R8", 16'h0175, b + 8'd3);
      wr(16'h0176, 8'h00);
      chk("R8", 16'h0172, a); chk("R8", 16'h0173, a + 8'd1);
      chk("R8", 16'h0174, a ^ 8'h5A); chk("R8", 16'h0175, a + 8'd3);
    end

    // R6 reserved bits forced
    wr(16'h0176, 8'h0F);
    chk("R6", 16'h0176, 8'hAF);
    wr(16'h0176, 8'h1F);
    chk("R6", 16'h0176, 8'hBF);
    chk("R6", 16'h0171, 8'h01);

    // R10 absent drive on channel 0
    wr(16'h01F2, 8'h22);
    wr(16'h01F6, 8'h13);
    chk("R10", 16'h01F6, 8'hA0);
    chk("R10", 16'h01F2, 8'h00);
    chk("R10", 16'h01F1, 8'h00);
    chk("R10", 16'h01F7, 8'h00);
    chk("R10", 16'h03F6, 8'h00);
    chk("R9",  16'h03F7, 8'hFF);
    wr(16'h01F6, 8'h03);
    chk("R6", 16'h01F7, 8'h01);
    chk("R6", 16'h01F1, 8'h05);
    chk("R6", 16'h01F6, 8'hA3);
    chk("R8", 16'h01F2, 8'h22);
    chk("R1", 16'h0177, 8'h00);
    chk("R1", 16'h0171, 8'h01);

    // R7 features write does not touch error
    wr(16'h01F1, 8'h55);
    chk("R7", 16'h01F1, 8'h05);

    // R11 command and data port writes have no visible effect
    wr(16'h01F7, 8'hEC);
    wr(16'h01F0, 8'h99);
    chk("R11", 16'h01F7, 8'h01);
    chk("R11", 16'h03F6, 8'h01);
    chk("R11", 16'h01F2, 8'h22);

    // R3 reset bit rise, R5 hold
    wr(16'h03F6, 8'h04);
    chk("R3", 16'h01F7, 8'h90);
    chk("R3", 16'h01F1, 8'h01);
    chk("R3", 16'h03F6, 8'h90);
    wr(16'h03F6, 8'h06);
    chk("R5", 16'h01F7, 8'h90);

    // R4 reset bit fall, R5 hold after release
    wr(16'h03F6, 8'h02);
    chk("R4", 16'h01F7, 8'h50);
    chk("R4", 16'h01F6, 8'hA0);
    chk("R4", 16'h01F2, 8'h01);
    chk("R4", 16'h01F3, 8'h01);
    chk("R4", 16'h01F4, 8'h00);
    chk("R4", 16'h01F5, 8'h00);
    wr(16'h03F6, 8'h00);
    chk("R5", 16'h01F7, 8'h50);
    chk("R1", 16'h0177, 8'h00);

    // R4 channel 1 signatures (drive1 disk selected, then drive0 packet)
    wr(16'h0376, 8'h04);
    wr(16'h0376, 8'h00);
    chk("R4", 16'h0176, 8'hB0);
    chk("R4", 16'h0174, 8'h00);
    chk("R4", 16'h0175, 8'h00);
    chk("R4", 16'h0172, 8'h01);
    wr(16'h0176, 8'h00);
    chk("R4", 16'h0174, 8'h14);
    chk("R4", 16'h0175, 8'hEB);
    chk("R4", 16'h0173, 8'h01);
    chk("R4", 16'h0177, 8'h50);
    chk("R1", 16'h01F7, 8'h50);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule